// File: doc/BRIEF.md
# Coincidence Multiplicity Event Classifier

This block sorts detector hits into two event kinds by looking at which readout cells fire together. Cells are grouped in fixed pairs, and each pair looks at one scintillator crystal. A hit that shows up on only one cell of a pair is a direct soft X-ray conversion in the silicon. Light that shows up on both cells of the same pair within a short window is scintillation from a hard X-ray or gamma photon that the crystal absorbed.

Each cell gives a one-cycle trigger strobe and an ADC sample. The first hit on a pair opens a pending slot for that pair and latches the external timestamp. The slot stays open for a window whose length is programmable in clock cycles. When the slot closes, it becomes one tagged record. The record carries a mode bit, a cell or crystal index, one or two energy words, a pile-up flag and the latched timestamp. Records leave through a valid/ready output. Any hit that cannot be accepted is counted in a saturating lost-hit counter.

One instance serves one quadrant of the detector plane. The default is 15 pairs (30 cells). Four instances cover 60 crystals and 120 channels, and each instance runs independently of the others.

Top module: `evtClassifier`

## Requirements
- R1: After reset, `outValid` is 0 and `lostCount` is 0.
- R2: A hit on cell c with no partner hit inside the window gives one record with `outMode`=0 (X-mode), `outIndex`=c, `outEnergyA` equal to that cell's sample, `outEnergyB`=0, and `outStamp` equal to `stamp` in the cycle of the hit.
- R3: A hit on the partner cell 1 to W-1 cycles after the first hit (W = `winCycles`) merges with it. The result is one record with `outMode`=1 (S-mode), `outIndex`=pair number p, `outEnergyA` from cell 2p, `outEnergyB` from cell 2p+1, and the timestamp of the first hit.
- R4: A partner hit exactly W cycles or more after the first hit does not merge. It gives two separate X-mode records.
- R5: Hits on both cells of a pair in the same cycle give one S-mode record.
- R6: Different pairs are handled independently. When several slots close in the same cycle, their records leave in ascending pair order, one per accepted transfer.
- R7: A hit on a cell that has already fired in the open slot sets `outPileup`=1 in that slot's record. The energy latched by the first hit on that cell is kept.
- R8: While `outValid`=1 and `outReady`=0, all record fields stay stable. Every hit strobe in such a cycle is dropped, and `lostCount` rises by the number of dropped strobes.
- R9: `lostCount` saturates at 2^LOSTW-1, which is 65535 by default.
- R10: A hit on a pair whose slot has closed but has not yet been transferred is dropped and counted in `lostCount`.
- R11: The window length is taken from `winCycles` while the block runs, and changing it changes the merge limit in R3/R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitStb | input | 30 | Per-cell trigger strobes; bit 2p and bit 2p+1 form pair p |
| hitAdc | input | 360 | Per-cell samples, cell c at bits [12c+11:12c] |
| stamp | input | 32 | External time tag, latched on the first hit of a slot |
| winCycles | input | 8 | Coincidence window length in cycles (0 treated as 1) |
| outReady | input | 1 | Downstream accepts the record |
| outValid | output | 1 | Record available |
| outMode | output | 1 | 0 = X-mode (lone cell), 1 = S-mode (pair) |
| outIndex | output | 5 | Cell index (X-mode) or pair index (S-mode) |
| outEnergyA | output | 12 | Lone-cell energy, or even-cell energy in S-mode |
| outEnergyB | output | 12 | Odd-cell energy in S-mode, 0 in X-mode |
| outPileup | output | 1 | Repeat hit seen during the window |
| outStamp | output | 32 | Timestamp of the slot's first hit |
| lostCount | output | 16 | Saturating count of dropped hit strobes |

## Verification
The timing tests place the partner hit at offsets of 0, W-1 and exactly W cycles for two window lengths. This separates a merge from two lone records right at the window edge.

Further tests cover hits on several pairs in the same cycle, which check independence and the order of output. A repeated hit on one cell checks that the pile-up flag is set and that the first energy is kept.

Two loss paths are tested apart. In the first, the output is held stalled. In the second, a hit lands on a slot that has closed but has not yet been transferred. A long burst of hits on all cells during a stall drives the lost counter into saturation.

// File: rtl/evtClassPkg.sv
package evtClassPkg;
  parameter int NPAIR = 15;
  parameter int ADCW  = 12;
  parameter int TSW   = 32;
  parameter int WINW  = 8;
  parameter int LOSTW = 16;

  localparam int NCELL = 2 * NPAIR;
  localparam int PIDXW = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int CIDXW = PIDXW + 1;
  localparam int DROPW = CIDXW + 1;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_OPEN  = 2'd1,
    SLOT_READY = 2'd2
  } slotState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic [NCELL-1:0] capCell;
    logic [NPAIR-1:0] capTs;
    logic             loadOut;
    logic [PIDXW-1:0] selPair;
    logic             selMode;
    logic             selOdd;
    logic             selPile;
    logic [DROPW-1:0] dropNum;
  } ctlStrobe_t;
endpackage

// File: rtl/evtCtrl.sv
module evtCtrl
  import evtClassPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCELL-1:0] hitStb,
  input  logic [WINW-1:0]  winCycles,
  input  logic             outReady,
  output logic             outValid,
  output ctlStrobe_t       strobe
);

  slotState_t      slotSt  [NPAIR];
  slotState_t      slotStN [NPAIR];
  logic [WINW-1:0] age     [NPAIR];
  logic [WINW-1:0] ageN    [NPAIR];
  logic [1:0]      seen    [NPAIR];
  logic [1:0]      seenN   [NPAIR];
  logic            pile    [NPAIR];
  logic            pileN   [NPAIR];
  logic            outValidQ;

  logic             stall;
  logic             canLoad;
  logic             grantHit;
  logic [PIDXW-1:0] grantIdx;

  always_comb begin
    stall    = outValidQ && !outReady;
    canLoad  = !outValidQ || outReady;
    grantHit = 1'b0;
    grantIdx = '0;
    for (int p = 0; p < NPAIR; p++) begin
      if (!grantHit && canLoad && slotSt[p] == SLOT_READY) begin
        grantHit = 1'b1;
        grantIdx = PIDXW'(p);
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.loadOut = grantHit;
    strobe.selPair = grantIdx;
    strobe.selMode = (seen[grantIdx] == 2'b11);
    strobe.selOdd  = seen[grantIdx][1];
    strobe.selPile = pile[grantIdx];
    for (int p = 0; p < NPAIR; p++) begin
      logic [1:0] h;
      logic       granted;
      h          = hitStb[2*p +: 2];
      granted    = grantHit && (grantIdx == PIDXW'(p));
      slotStN[p] = slotSt[p];
      ageN[p]    = age[p];
      seenN[p]   = seen[p];
      pileN[p]   = pile[p];
      if (granted) slotStN[p] = SLOT_IDLE;
      if (slotSt[p] == SLOT_OPEN) begin
        ageN[p] = age[p] + WINW'(1);
        if (({1'b0, age[p]} + (WINW+1)'(2)) >= {1'b0, winCycles})
          slotStN[p] = SLOT_READY;
      end
      if (stall) begin
        strobe.dropNum = strobe.dropNum + DROPW'(h[0]) + DROPW'(h[1]);
      end else if (slotSt[p] == SLOT_IDLE || granted) begin
        if (h != 2'b00) begin
          seenN[p]   = h;
          pileN[p]   = 1'b0;
          ageN[p]    = '0;
          slotStN[p] = (winCycles <= WINW'(1)) ? SLOT_READY : SLOT_OPEN;
          strobe.capCell[2*p +: 2] = h;
          strobe.capTs[p]          = 1'b1;
        end
      end else if (slotSt[p] == SLOT_OPEN) begin
        if (h != 2'b00) begin
          pileN[p] = pile[p] | (|(h & seen[p]));
          seenN[p] = seen[p] | h;
          strobe.capCell[2*p +: 2] = h & ~seen[p];
        end
      end else begin
        strobe.dropNum = strobe.dropNum + DROPW'(h[0]) + DROPW'(h[1]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      for (int p = 0; p < NPAIR; p++) begin
        slotSt[p] <= SLOT_IDLE;
        age[p]    <= '0;
        seen[p]   <= '0;
        pile[p]   <= 1'b0;
      end
    end else begin
      if (grantHit)      outValidQ <= 1'b1;
      else if (outReady) outValidQ <= 1'b0;
      for (int p = 0; p < NPAIR; p++) begin
        slotSt[p] <= slotStN[p];
        age[p]    <= ageN[p];
        seen[p]   <= seenN[p];
        pile[p]   <= pileN[p];
      end
    end
  end

  assign outValid = outValidQ;

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValidQ && !outReady) |=> outValidQ);

  p_load_sets_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |=> outValidQ);

endmodule

// File: rtl/evtPath.sv
module evtPath
  import evtClassPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCELL*ADCW-1:0] hitAdc,
  input  logic [TSW-1:0]        stamp,
  input  ctlStrobe_t            strobe,
  input  logic                  outValid,
  input  logic                  outReady,
  output logic                  outMode,
  output logic [CIDXW-1:0]      outIndex,
  output logic [ADCW-1:0]       outEnergyA,
  output logic [ADCW-1:0]       outEnergyB,
  output logic                  outPileup,
  output logic [TSW-1:0]        outStamp,
  output logic [LOSTW-1:0]      lostCount
);

  localparam logic [LOSTW:0] LOST_MAX = {1'b0, {LOSTW{1'b1}}};

  logic [ADCW-1:0]  eng    [NCELL];
  logic [TSW-1:0]   tsSlot [NPAIR];
  logic [LOSTW-1:0] lostQ;
  logic [LOSTW:0]   lostSum;

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rstN)                  eng[c] <= '0;
      else if (strobe.capCell[c]) eng[c] <= hitAdc[c*ADCW +: ADCW];
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rstN)                tsSlot[p] <= '0;
      else if (strobe.capTs[p]) tsSlot[p] <= stamp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outMode    <= 1'b0;
      outIndex   <= '0;
      outEnergyA <= '0;
      outEnergyB <= '0;
      outPileup  <= 1'b0;
      outStamp   <= '0;
    end else if (strobe.loadOut) begin
      outMode   <= strobe.selMode;
      outPileup <= strobe.selPile;
      outStamp  <= tsSlot[strobe.selPair];
      if (strobe.selMode) begin
        outIndex   <= CIDXW'(strobe.selPair);
        outEnergyA <= eng[{strobe.selPair, 1'b0}];
        outEnergyB <= eng[{strobe.selPair, 1'b1}];
      end else begin
        outIndex   <= {strobe.selPair, strobe.selOdd};
        outEnergyA <= eng[{strobe.selPair, strobe.selOdd}];
        outEnergyB <= '0;
      end
    end
  end

  assign lostSum = {1'b0, lostQ} + (LOSTW+1)'(strobe.dropNum);

  always_ff @(posedge clk) begin
    if (!rstN)                  lostQ <= '0;
    else if (lostSum > LOST_MAX) lostQ <= {LOSTW{1'b1}};
    else                         lostQ <= lostSum[LOSTW-1:0];
  end

  assign lostCount = lostQ;

  p_stall_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outEnergyA) && $stable(outEnergyB)
                                 && $stable(outIndex) && $stable(outStamp)));

  p_lost_monotonic_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (lostQ >= $past(lostQ)));

  p_x_single_energy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outMode) |-> (outEnergyB == '0));

  p_s_index_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMode) |-> (int'(outIndex) < NPAIR));

endmodule

// File: rtl/evtClassifier.sv
module evtClassifier
  import evtClassPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCELL-1:0]      hitStb,
  input  logic [NCELL*ADCW-1:0] hitAdc,
  input  logic [TSW-1:0]        stamp,
  input  logic [WINW-1:0]       winCycles,
  input  logic                  outReady,
  output logic                  outValid,
  output logic                  outMode,
  output logic [CIDXW-1:0]      outIndex,
  output logic [ADCW-1:0]       outEnergyA,
  output logic [ADCW-1:0]       outEnergyB,
  output logic                  outPileup,
  output logic [TSW-1:0]        outStamp,
  output logic [LOSTW-1:0]      lostCount
);

  ctlStrobe_t strobe;

  evtCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hitStb    (hitStb),
    .winCycles (winCycles),
    .outReady  (outReady),
    .outValid  (outValid),
    .strobe    (strobe)
  );

  evtPath i_path (
    .clk        (clk),
    .rstN       (rstN),
    .hitAdc     (hitAdc),
    .stamp      (stamp),
    .strobe     (strobe),
    .outValid   (outValid),
    .outReady   (outReady),
    .outMode    (outMode),
    .outIndex   (outIndex),
    .outEnergyA (outEnergyA),
    .outEnergyB (outEnergyB),
    .outPileup  (outPileup),
    .outStamp   (outStamp),
    .lostCount  (lostCount)
  );

endmodule

// File: tb/test_evtClassifier.sv
module test_evtClassifier;
  localparam int CLK_PERIOD = 10;
  localparam int NCELL = 30;
  localparam int ADCW  = 12;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic [NCELL-1:0]      hitStb = '0;
  logic [NCELL*ADCW-1:0] hitAdc = '0;
  logic [31:0]           stamp = '0;
  logic [7:0]            winCycles = 8'd2;
  logic                  outReady = 1'b1;
  logic                  outValid, outMode, outPileup;
  logic [4:0]            outIndex;
  logic [11:0]           outEnergyA, outEnergyB;
  logic [31:0]           outStamp;
  logic [15:0]           lostCount;

  typedef struct {
    logic        mode;
    int          idx;
    logic [11:0] a;
    logic [11:0] b;
    logic        pile;
    logic [31:0] ts;
    string       req;
  } rec_t;

  rec_t expQ[$];
  int   nCompared = 0;
  int   nMismatch = 0;
  int   expLost = 0;
  bit   doneFlag = 1'b0;

  evtClassifier i_evtClassifier (
    .clk(clk), .rstN(rstN), .hitStb(hitStb), .hitAdc(hitAdc), .stamp(stamp),
    .winCycles(winCycles), .outReady(outReady), .outValid(outValid),
    .outMode(outMode), .outIndex(outIndex), .outEnergyA(outEnergyA),
    .outEnergyB(outEnergyB), .outPileup(outPileup), .outStamp(outStamp),
    .lostCount(lostCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse(input logic [NCELL-1:0] mask, input int base, input int ts);
    hitStb = mask;
    for (int c = 0; c < NCELL; c++) hitAdc[c*ADCW +: ADCW] = 12'(base + c);
    stamp = 32'(ts);
    tick();
    hitStb = '0;
  endtask

  task automatic push(input logic mode, input int idx, input int a, input int b,
                      input logic pile, input int ts, input string req);
    rec_t r;
    r.mode = mode; r.idx = idx; r.a = 12'(a); r.b = 12'(b);
    r.pile = pile; r.ts = 32'(ts); r.req = req;
    expQ.push_back(r);
  endtask

  task automatic drain(input string req);
    idle(14);
    check(expQ.size() == 0, {req, " records left"}, expQ.size(), 0);
    expQ.delete();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "unexpected record idx", outIndex, -1);
      end else begin
        rec_t e;
        e = expQ.pop_front();
        check(outMode == e.mode, {e.req, " mode"}, outMode, e.mode);
        check(int'(outIndex) == e.idx, {e.req, " index"}, outIndex, e.idx);
        check(outEnergyA == e.a, {e.req, " energyA"}, outEnergyA, e.a);
        check(outEnergyB == e.b, {e.req, " energyB"}, outEnergyB, e.b);
        check(outPileup == e.pile, {e.req, " pileup"}, outPileup, e.pile);
        check(outStamp == e.ts, {e.req, " stamp"}, outStamp, e.ts);
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (doneFlag) break;
    end
    if (!doneFlag) begin
      check(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    tick();
    check(outValid == 1'b0, "R1 valid after reset", outValid, 0);
    check(lostCount == 16'd0, "R1 lost after reset", lostCount, 0);

    // R2 lone hit, W=2
    winCycles = 8'd2;
    push(0, 0, 100, 0, 0, 11, "R2");
    pulse(30'h1, 100, 11);
    drain("R2");

    // R3 partner at offset 1, W=2
    push(1, 1, 202, 303, 0, 21, "R3");
    pulse(30'h4, 200, 21);
    pulse(30'h8, 300, 22);
    drain("R3");

    // R4 partner at offset W=2 -> two X records
    push(0, 4, 404, 0, 0, 31, "R4 first");
    push(0, 5, 505, 0, 0, 33, "R4 second");
    pulse(30'h10, 400, 31);
    idle(1);
    pulse(30'h20, 500, 33);
    drain("R4");

    // R11 window 5: offset 4 merges, offset 5 splits
    winCycles = 8'd5;
    push(1, 3, 606, 707, 0, 41, "R11 merge");
    pulse(30'h40, 600, 41);
    idle(3);
    pulse(30'h80, 700, 45);
    drain("R11 merge");
    push(0, 6, 806, 0, 0, 51, "R11 split first");
    push(0, 7, 907, 0, 0, 56, "R11 split second");
    pulse(30'h40, 800, 51);
    idle(4);
    pulse(30'h80, 900, 56);
    drain("R11 split");

    // R5 both cells same cycle
    winCycles = 8'd3;
    push(1, 4, 1008, 1009, 0, 61, "R5");
    pulse(30'h300, 1000, 61);
    drain("R5");

    // R7 repeat hit on cell 10 inside window
    winCycles = 8'd4;
    push(1, 5, 1110, 1211, 1, 71, "R7");
    pulse(30'h400, 1100, 71);
    pulse(30'h800, 1200, 72);
    pulse(30'h400, 1300, 73);
    drain("R7");

    // R6 two pairs at once, ascending pair order
    winCycles = 8'd3;
    push(0, 1, 1401, 0, 0, 81, "R6 pair0");
    push(0, 6, 1406, 0, 0, 81, "R6 pair3");
    pulse(30'h42, 1400, 81);
    drain("R6");

    // R10 hit on a closed slot awaiting transfer is dropped
    winCycles = 8'd2;
    push(0, 0, 1500, 0, 0, 91, "R10 pair0");
    push(0, 2, 1502, 0, 0, 91, "R10 pair1");
    pulse(30'h5, 1500, 91);
    idle(1);
    pulse(30'h8, 1600, 93);
    expLost += 1;
    drain("R10");
    check(int'(lostCount) == expLost, "R10 lost count", lostCount, expLost);

    // R8 stall holds record and drops hits
    outReady = 1'b0;
    push(0, 12, 1712, 0, 0, 101, "R8");
    pulse(30'h1000, 1700, 101);
    idle(3);
    check(outValid == 1'b1, "R8 valid held", outValid, 1);
    pulse(30'hC000, 1800, 102);
    pulse(30'h100000, 1900, 103);
    expLost += 3;
    idle(2);
    check(int'(lostCount) == expLost, "R8 lost count", lostCount, expLost);
    check(outEnergyA == 12'd1712, "R8 energy held", outEnergyA, 1712);
    check(outIndex == 5'd12, "R8 index held", outIndex, 12);
    outReady = 1'b1;
    drain("R8");

    // R9 saturation of the lost counter
    outReady = 1'b0;
    push(0, 0, 2000, 0, 0, 111, "R9");
    pulse(30'h1, 2000, 111);
    idle(3);
    hitStb = '1;
    idle(2300);
    hitStb = '0;
    idle(1);
    check(lostCount == 16'hFFFF, "R9 saturated", lostCount, 65535);
    outReady = 1'b1;
    drain("R9");
    check(lostCount == 16'hFFFF, "R9 stays saturated", lostCount, 65535);

    doneFlag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end
endmodule